// File: doc/BRIEF.md
# Odd-Even Transposition Window Sorter

This block takes one complete window of unsigned pixels, presented in parallel as a single flat vector together with a valid strobe. It ranks the window through a fully unrolled odd-even transposition network and returns three order statistics: the smallest value, the middle value and the largest value. The window holds an odd number of pixels. Typical sizes are 9, 25, 49 and 81, which are square neighbourhoods of side 3, 5, 7 and 9.

The network has as many passes as the window has pixels, and its pairing alternates from pass to pass. Pipeline registers can be placed after every few passes, as set by a parameter. This gives a trade between clock rate and latency. The valid strobe travels through the same registers as the data, so each result arrives with its own flag. A new window can be accepted on every clock cycle.

The block is meant to sit inside a rank-order or median image filter. That filter builds the windows from its line buffers and decides how to use the three statistics.

Top module: `oets_window_sorter`

## Requirements
- R1: When `out_valid` is high, `out_min` equals the smallest pixel of the window that was accepted LAT cycles earlier.
- R2: When `out_valid` is high, `out_max` equals the largest pixel of that window.
- R3: When `out_valid` is high, `out_med` equals the value at rank (N+1)/2 of that window in ascending order, counting from 1. Duplicates are counted individually.
- R4: `out_valid` rises exactly LAT = ceil(N / PASSES_PER_REG) rising edges after the edge that accepted a window with `in_valid` high. It is low for cycles that carried no window, including gaps between windows.
- R5: Windows presented on consecutive cycles produce results on consecutive cycles, in the same order, with no stall.
- R6: While `rst` is high at a rising edge, the next cycle shows `out_valid` low and all three statistics at zero.
- R7: A window whose pixels all share one value yields that value on all three outputs.
- R8: Windows already in ascending order and windows in descending order are fully ranked. The N passes are enough for both extremes.
- R9: Whenever `out_valid` is high, `out_min` <= `out_med` <= `out_max`.
- R10: Pixel k of the window (k = 0 .. N-1) occupies bits [k*W +: W] of `in_pix`. The result does not depend on the order in which pixels are placed in the vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_pix` carries a window to accept |
| in_pix | input | N*W | Flat window, pixel k at bits [k*W +: W] |
| out_valid | output | 1 | High when the three statistics belong to an accepted window |
| out_min | output | W | Smallest pixel of the window |
| out_med | output | W | Pixel at rank (N+1)/2 |
| out_max | output | W | Largest pixel of the window |

## Verification
The hardest case to reach from the ports is a window that needs every one of the N passes to settle. In such a window a single value must travel from one end of the vector to the other, or the whole order is reversed. Random data rarely produces this. The stimulus table therefore places fully ascending and fully descending windows next to heavy-duplicate and alternating-extreme windows, all pushed back to back. A later phase inserts gaps into the valid stream and applies reset while the pipeline is full. This shows that results and flags stay aligned through bubbles and that no stale window survives a reset.

// File: rtl/oets_pkg.sv
package oets_pkg;

    // Which neighbour pairing a pass uses
    typedef enum logic {
        PAIR_LOW  = 1'b0,   // pairs (0,1),(2,3)...; top element passes through
        PAIR_HIGH = 1'b1    // pairs (1,2),(3,4)...; bottom element passes through
    } pair_phase_e;

    // Pass numbers start at 1; odd passes pair from the bottom
    function automatic pair_phase_e pass_phase(input int pass_no);
        return (pass_no % 2 == 1) ? PAIR_LOW : PAIR_HIGH;
    endfunction

    // A register follows every PPR-th pass and always the final pass
    function automatic bit reg_after_pass(input int pass_no, input int n, input int ppr);
        return (pass_no % ppr == 0) || (pass_no == n);
    endfunction

    function automatic int pipe_latency(input int n, input int ppr);
        return (n + ppr - 1) / ppr;
    endfunction

    // 0-based index of the middle rank of an odd window
    function automatic int mid_index(input int n);
        return (n - 1) / 2;
    endfunction

endpackage

// File: rtl/oets_cmp_swap.sv
module oets_cmp_swap #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    // Swap only on strict inversion so equal values keep their places
    always_comb begin
        if (b < a) begin
            lo = b;
            hi = a;
        end else begin
            lo = a;
            hi = b;
        end
    end
endmodule

// File: rtl/oets_pass.sv
module oets_pass #(
    parameter int                     N     = 9,
    parameter int                     W     = 8,
    parameter oets_pkg::pair_phase_e  PHASE = oets_pkg::PAIR_LOW
) (
    input  logic [N*W-1:0] din,
    output logic [N*W-1:0] dout
);
    localparam int FIRST  = (PHASE == oets_pkg::PAIR_LOW) ? 0 : 1;
    localparam int NPAIRS = (N - 1) / 2;
    localparam int SPARE  = (PHASE == oets_pkg::PAIR_LOW) ? N - 1 : 0;

    for (genvar k = 0; k < NPAIRS; k++) begin : g_pair
        localparam int LO = FIRST + 2 * k;
        oets_cmp_swap #(.W(W)) u_cx (
            .a  (din[LO*W +: W]),
            .b  (din[(LO+1)*W +: W]),
            .lo (dout[LO*W +: W]),
            .hi (dout[(LO+1)*W +: W])
        );
    end

    // The single unpaired element of this pass
    assign dout[SPARE*W +: W] = din[SPARE*W +: W];
endmodule

// File: rtl/oets_pipe_reg.sv
module oets_pipe_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/oets_window_sorter.sv
module oets_window_sorter #(
    parameter int N              = 9,
    parameter int W              = 8,
    parameter int PASSES_PER_REG = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [N*W-1:0] in_pix,
    output logic           out_valid,
    output logic [W-1:0]   out_min,
    output logic [W-1:0]   out_med,
    output logic [W-1:0]   out_max
);
    localparam int LAT = oets_pkg::pipe_latency(N, PASSES_PER_REG);
    localparam int MID = oets_pkg::mid_index(N);
    localparam int BW  = N * W + 1;   // window plus its valid flag

    // lane[p] is the window after p passes; flag[p] its valid bit
    logic [N*W-1:0] lane [0:N];
    logic           flag [0:N];

    assign lane[0] = in_pix;
    assign flag[0] = in_valid;

    for (genvar p = 1; p <= N; p++) begin : g_pass
        logic [N*W-1:0] sorted;

        oets_pass #(
            .N     (N),
            .W     (W),
            .PHASE (oets_pkg::pass_phase(p))
        ) u_pass (
            .din  (lane[p-1]),
            .dout (sorted)
        );

        if (oets_pkg::reg_after_pass(p, N, PASSES_PER_REG)) begin : g_reg
            logic [BW-1:0] q_bus;
            oets_pipe_reg #(.WIDTH(BW)) u_reg (
                .clk (clk),
                .rst (rst),
                .d   ({flag[p-1], sorted}),
                .q   (q_bus)
            );
            assign flag[p] = q_bus[BW-1];
            assign lane[p] = q_bus[BW-2:0];
        end else begin : g_wire
            assign flag[p] = flag[p-1];
            assign lane[p] = sorted;
        end
    end

    assign out_valid = flag[N];
    assign out_min   = lane[N][0 +: W];
    assign out_med   = lane[N][MID*W +: W];
    assign out_max   = lane[N][(N-1)*W +: W];
endmodule

// File: rtl/oets_window_sorter_chk.sv
module oets_window_sorter_chk #(
    parameter int N              = 9,
    parameter int W              = 8,
    parameter int PASSES_PER_REG = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [N*W-1:0] in_pix,
    input logic           out_valid,
    input logic [W-1:0]   out_min,
    input logic [W-1:0]   out_med,
    input logic [W-1:0]   out_max
);
    localparam int LAT = oets_pkg::pipe_latency(N, PASSES_PER_REG);

    logic           all_same;
    logic [LAT-1:0] v_hist;
    logic [LAT-1:0] same_hist;

    always_comb begin
        all_same = 1'b1;
        for (int k = 1; k < N; k++) begin
            if (in_pix[k*W +: W] != in_pix[0 +: W]) all_same = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_hist    <= '0;
            same_hist <= '0;
        end else begin
            v_hist    <= (v_hist << 1) | LAT'(in_valid);
            same_hist <= (same_hist << 1) | LAT'(in_valid & all_same);
        end
    end

    // R9: ranked outputs are ordered
    p_rank_order_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_min <= out_med) && (out_med <= out_max));

    // R4: flag emerges exactly LAT edges after acceptance
    p_valid_delay_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_hist[LAT-1]);

    // R7: a uniform window collapses all statistics
    p_uniform_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && same_hist[LAT-1]) |-> (out_min == out_max) && (out_med == out_min));

    // R6: the cycle after reset is empty and zeroed
    p_reset_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid && out_min == '0 && out_med == '0 && out_max == '0);
endmodule

bind oets_window_sorter oets_window_sorter_chk #(
    .N (N), .W (W), .PASSES_PER_REG (PASSES_PER_REG)
) u_chk (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_pix (in_pix),
    .out_valid (out_valid), .out_min (out_min), .out_med (out_med), .out_max (out_max)
);

// File: tb/oets_window_sorter_bench.sv
module oets_window_sorter_bench;
    localparam int N   = 9;
    localparam int W   = 8;
    localparam int PPR = 3;
    localparam int LAT = (N + PPR - 1) / PPR;
    localparam int NT  = 8;
    localparam int QD  = 1024;

    // Hand-ranked windows; pixel k listed right-to-left (k=8 first)
    localparam logic [N*W-1:0] TBL_WIN [0:NT-1] = '{
        {8'd6, 8'd4, 8'd7, 8'd2, 8'd9, 8'd1, 8'd8, 8'd3, 8'd5},
        {8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7},
        {8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1},
        {8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd9},
        {8'd0, 8'd255, 8'd0, 8'd255, 8'd0, 8'd255, 8'd0, 8'd255, 8'd0},
        {8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255},
        {8'd200, 8'd200, 8'd200, 8'd200, 8'd200, 8'd10, 8'd10, 8'd10, 8'd10},
        {8'd5, 8'd9, 8'd9, 8'd2, 8'd2, 8'd1, 8'd1, 8'd3, 8'd3}
    };
    // {min, med, max}
    localparam logic [3*W-1:0] TBL_EXP [0:NT-1] = '{
        {8'd1, 8'd5, 8'd9},
        {8'd7, 8'd7, 8'd7},
        {8'd1, 8'd5, 8'd9},
        {8'd1, 8'd5, 8'd9},
        {8'd0, 8'd0, 8'd255},
        {8'd255, 8'd255, 8'd255},
        {8'd10, 8'd200, 8'd200},
        {8'd1, 8'd3, 8'd9}
    };
    // 0 plain, 1 uniform, 2 pre-ordered
    localparam int TBL_KIND [0:NT-1] = '{0, 1, 2, 2, 0, 1, 0, 0};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [N*W-1:0] in_pix = '0;
    logic           out_valid;
    logic [W-1:0]   out_min, out_med, out_max;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int wr = 0;
    int rd = 0;
    bit finished = 1'b0;

    logic [3*W-1:0] q_exp  [0:QD-1];
    int             q_kind [0:QD-1];
    int             q_push [0:QD-1];
    int             q_pop  [0:QD-1];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    oets_window_sorter #(.N(N), .W(W), .PASSES_PER_REG(PPR)) u_oets_window_sorter (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_pix (in_pix),
        .out_valid (out_valid), .out_min (out_min), .out_med (out_med), .out_max (out_max)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3*W-1:0] ref_rank(input logic [N*W-1:0] v);
        int a [N];
        for (int i = 0; i < N; i++) a[i] = int'(v[i*W +: W]);
        for (int i = 1; i < N; i++) begin
            for (int j = i; j > 0 && a[j-1] > a[j]; j--) begin
                int t = a[j];
                a[j] = a[j-1];
                a[j-1] = t;
            end
        end
        return {W'(a[0]), W'(a[(N-1)/2]), W'(a[N-1])};
    endfunction

    task automatic push(input logic [N*W-1:0] v, input logic [3*W-1:0] e, input int kind);
        @(negedge clk);
        in_valid = 1'b1;
        in_pix   = v;
        q_exp[wr % QD]  = e;
        q_kind[wr % QD] = kind;
        q_push[wr % QD] = cyc;
        wr++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_pix   = {N*W{1'b1}};
        end
    endtask

    // Output monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (rd >= wr) begin
                chk(1'b0, "R4 spurious valid", 1, 0);
            end else begin
                logic [3*W-1:0] e;
                e = q_exp[rd % QD];
                chk(out_min == e[2*W +: W], "R1 min", out_min, e[2*W +: W]);
                chk(out_med == e[W +: W], "R3 med", out_med, e[W +: W]);
                chk(out_max == e[0 +: W], "R2 max", out_max, e[0 +: W]);
                chk(cyc - q_push[rd % QD] == LAT, "R4 latency", cyc - q_push[rd % QD], LAT);
                chk(out_min <= out_med && out_med <= out_max, "R9 order", out_med, out_med);
                if (q_kind[rd % QD] == 1)
                    chk(out_min == out_max && out_med == out_min, "R7 uniform", out_max, out_min);
                if (q_kind[rd % QD] == 2)
                    chk(out_med == e[W +: W], "R8 pre-ordered", out_med, e[W +: W]);
                q_pop[rd % QD] = cyc;
                rd++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset state, R6
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 reset valid", out_valid, 0);
        chk(out_min == 0 && out_med == 0 && out_max == 0, "R6 reset data", out_max, 0);
        rst = 1'b0;

        // Table burst, back to back (R1 R2 R3 R5 R7 R8)
        for (int t = 0; t < NT; t++) push(TBL_WIN[t], TBL_EXP[t], TBL_KIND[t]);
        idle(LAT + 3);
        chk(rd == NT, "R5 burst count", rd, NT);
        chk(q_pop[NT-1] - q_pop[0] == NT - 1, "R5 consecutive", q_pop[NT-1] - q_pop[0], NT - 1);

        // R10: same contents, rotated placement
        for (int r = 1; r < N; r++) begin
            logic [N*W-1:0] v;
            v = {TBL_WIN[0], TBL_WIN[0]} >> (r * W);
            push(v, TBL_EXP[0], 0);
        end
        idle(LAT + 2);
        chk(rd == wr, "R10 rotations drained", rd, wr);

        // Random windows, back to back then with gaps
        for (int i = 0; i < 300; i++) begin
            logic [N*W-1:0] v;
            for (int k = 0; k < N; k++) v[k*W +: W] = W'($urandom_range(0, (i % 3 == 0) ? 3 : 255));
            push(v, ref_rank(v), 0);
            if (i >= 150 && ($urandom % 3) == 0) idle(($urandom % 3) + 1);
        end
        idle(LAT + 2);
        chk(rd == wr, "R4 all windows returned", rd, wr);

        // Reset with a full pipeline, R6
        for (int i = 0; i < LAT; i++) begin
            logic [N*W-1:0] v;
            for (int k = 0; k < N; k++) v[k*W +: W] = W'($urandom);
            push(v, ref_rank(v), 0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 mid-run valid", out_valid, 0);
        chk(out_min == 0 && out_med == 0 && out_max == 0, "R6 mid-run data", out_min, 0);
        rd = wr;
        rst = 1'b0;
        idle(LAT + 2);
        chk(rd == wr, "R6 no stale output", rd, wr);

        // Recovery after reset
        push(TBL_WIN[7], TBL_EXP[7], 0);
        push(TBL_WIN[2], TBL_EXP[2], 2);
        idle(LAT + 2);
        chk(rd == wr, "R4 recovery drained", rd, wr);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule